// File: doc/BRIEF.md
# Vectored Maskable Interrupt Controller

This block gathers seventeen interrupt request lines into one request and one vector index for a small processor core. Each line has a pending flag that is set by an event and cleared only when the processor acknowledges that line's vector. A per-line enable mask decides which pending flags may reach the processor. Among the enabled pending flags, the lowest source index always wins, and that index is presented as the vector.

Three of the lines come from individual GPIO pins and are edge sensitive. Each has a configuration bit that selects whether a rising or a falling transition counts as an event. A registered copy of each pin's previous level makes one transition produce one event. The power-on-reset event and the low-voltage event are merged onto line 0 and share its vector. A global enable level gates the request output without disturbing any pending flag.

Source numbering, which also sets priority: 0 supply monitor, 1 interval timer, 2 periodic tick of the free-running timer, 3 and 4 capture units A and B, 5 to 9 GPIO ports 0 to 4, 10 to 12 edge-sensitive GPIO pins 0 to 2, 13 and 14 the two SPI events, 15 free-running-timer wrap, 16 wakeup timer.

Top module: `intc_vectored`

## Requirements
- R1: After a synchronous reset, every pending flag is clear, every mask bit is 0 (source disabled), every pin polarity bit is 1 (rising), `irq_o` is 0 and `vec_o` is 0.
- R2: A level source (1 to 9, 13 to 16) that is high at a rising clock edge sets its pending flag at that edge. If the source is enabled and `gie_i` is high, `irq_o` rises right after that edge.
- R3: A high `supply_por_i` or a high `supply_lvd_i`, or both in the same cycle, sets the single pending flag of source 0. Both high in the same cycle gives exactly one vector-0 event.
- R4: Bit k of `pol_wdata_i`, written when `pol_we_i` is high, sets the polarity of pin source 10+k. A value of 1 sets the flag on a 0-to-1 transition of `src_i[10+k]`, and a value of 0 sets it on a 1-to-0 transition. The opposite transition sets nothing.
- R5: One qualifying pin transition followed by a steady level produces exactly one pending event. Once that event is acknowledged, the pin raises no further request until it moves again.
- R6: When any enabled pending flag exists, `vec_o` equals the lowest index among the enabled pending flags.
- R7: Bit k of `mask_wdata_i`, written when `mask_we_i` is high, enables source k (1 = enabled). A pending flag on a disabled source is kept. It is presented as soon as its mask bit is set. A disabled pending flag never blocks a higher-index enabled one.
- R8: While `gie_i` is 0, `irq_o` is 0 and no pending flag is lost. Raising `gie_i` presents the stored requests in the same cycle.
- R9: `ack_i` high at a clock edge while `irq_o` is 1 clears only the flag of the presented vector. If a new event for that same source arrives at that edge, the flag stays set.
- R10: `vec_o` is 0 whenever `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| supply_por_i | input | 1 | Power-on-reset event (source 0) |
| supply_lvd_i | input | 1 | Low-voltage event (source 0) |
| src_i | input | 16 | Raw requests for sources 1 to 16 (bit n is source n) |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 17 | Mask write data, bit k enables source k |
| pol_we_i | input | 1 | Pin polarity write strobe |
| pol_wdata_i | input | 3 | Polarity data, bit k for pin source 10+k, 1 rising |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Acknowledge of the presented vector |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 5 | Vector index of the presented source |

## Verification
A flag that is set, lost or cleared wrongly shows up at the ports as a vector that appears, disappears or repeats when the bench drains all pending flags by acknowledging one vector per cycle. Every such drain runs right after the stimulus, so a fault becomes visible within a few cycles. A faulty priority chain or mask gate changes `vec_o` in the cycle after the events are latched. A broken pin edge detector shows up as a missing or doubled vector in the drain that follows each pin transition.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NUM_SRC    = 17;
    localparam int VEC_W      = $clog2(NUM_SRC);
    localparam int NUM_PIN    = 3;
    localparam int PIN_BASE   = 10;
    localparam int SUPPLY_IDX = 0;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [VEC_W-1:0]   vec_t;

    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } edge_pol_e;

    typedef struct packed {
        logic valid;
        vec_t idx;
    } grant_t;

    function automatic src_vec_t one_hot(input vec_t idx);
        src_vec_t r;
        r = '0;
        r[idx] = 1'b1;
        return r;
    endfunction

    function automatic src_vec_t lower_than(input vec_t idx);
        src_vec_t r;
        for (int i = 0; i < NUM_SRC; i++)
            r[i] = (i < int'(idx));
        return r;
    endfunction

    function automatic logic is_pin(input int idx);
        return (idx >= PIN_BASE) && (idx < PIN_BASE + NUM_PIN);
    endfunction

endpackage

// File: rtl/intc_edge_detect.sv
module intc_edge_detect
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic pol_we_i,
    input  logic pol_bit_i,
    output logic evt_o
);

    logic      prev_q;
    edge_pol_e pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pol_q  <= POL_RISE;
        end else begin
            prev_q <= pin_i;
            if (pol_we_i)
                pol_q <= edge_pol_e'(pol_bit_i);
        end
    end

    always_comb begin
        if (pol_q == POL_RISE)
            evt_o = pin_i & ~prev_q;
        else
            evt_o = ~pin_i & prev_q;
    end

    // R5: a steady pin under a steady polarity gives no second event
    assert_single_event_R5: assert property (@(posedge clk) disable iff (rst)
        evt_o |=> (!evt_o || !$stable(pol_bit_i) || $past(pol_we_i) || pol_we_i));

endmodule

// File: rtl/intc_pending_bank.sv
module intc_pending_bank
    import intc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] pend_q;
    logic [N-1:0] pend_d;

    always_comb pend_d = (pend_q & ~clr_i) | set_i;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    assert_clr_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_i));

    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

    assert_clear_only_acked_R9: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

    assert_retained_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0));

endmodule

// File: rtl/intc_prio_encoder.sv
module intc_prio_encoder
    import intc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t req_i,
    output grant_t   grant_o
);

    always_comb begin
        grant_o.valid = 1'b0;
        grant_o.idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o.valid = 1'b1;
                grant_o.idx   = vec_t'(i);
            end
        end
    end

    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (rst)
        grant_o.valid |-> (req_i[grant_o.idx] && ((req_i & lower_than(grant_o.idx)) == '0)));

    assert_valid_any_R6: assert property (@(posedge clk) disable iff (rst)
        grant_o.valid == (|req_i));

endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
    import intc_pkg::*;
#(
    parameter int N     = NUM_SRC,
    parameter int VW    = VEC_W,
    parameter int NPIN  = NUM_PIN,
    parameter int PBASE = PIN_BASE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          supply_por_i,
    input  logic          supply_lvd_i,
    input  logic [N-1:1]  src_i,
    input  logic          mask_we_i,
    input  logic [N-1:0]  mask_wdata_i,
    input  logic          pol_we_i,
    input  logic [NPIN-1:0] pol_wdata_i,
    input  logic          gie_i,
    input  logic          ack_i,
    output logic          irq_o,
    output logic [VW-1:0] vec_o
);

    src_vec_t set_vec;
    src_vec_t clr_vec;
    src_vec_t pend;
    src_vec_t mask_q;
    src_vec_t req;
    grant_t   grant;
    logic [NPIN-1:0] pin_evt;

    // edge-sensitive pins
    for (genvar k = 0; k < NPIN; k++) begin : g_pin
        intc_edge_detect u_edge (
            .clk       (clk),
            .rst       (rst),
            .pin_i     (src_i[PBASE + k]),
            .pol_we_i  (pol_we_i),
            .pol_bit_i (pol_wdata_i[k]),
            .evt_o     (pin_evt[k])
        );
    end

    // event vector: shared supply line, pins through detectors, rest level
    assign set_vec[SUPPLY_IDX] = supply_por_i | supply_lvd_i;
    for (genvar i = 1; i < N; i++) begin : g_set
        if (is_pin(i)) begin : g_edge
            assign set_vec[i] = pin_evt[i - PBASE];
        end else begin : g_level
            assign set_vec[i] = src_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_wdata_i;
    end

    intc_pending_bank #(.N(N)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    assign req = pend & mask_q;

    intc_prio_encoder u_prio (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .grant_o (grant)
    );

    assign irq_o   = gie_i & grant.valid;
    assign vec_o   = irq_o ? grant.idx : '0;
    assign clr_vec = (ack_i && irq_o) ? one_hot(grant.idx) : '0;

    assert_gie_gates_R8: assert property (@(posedge clk) disable iff (rst)
        !gie_i |-> !irq_o);

    assert_vec_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> (vec_o == '0));

    assert_vec_enabled_R7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (mask_q[vec_o] && pend[vec_o]));

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (pend == '0 && mask_q == '0 && !irq_o));

endmodule

// File: tb/intc_vectored_test.sv
module intc_vectored_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NS-1:0] drv = '0;
    logic lvd = 1'b0;
    logic mask_we = 1'b0;
    logic [NS-1:0] mask_wd = '0;
    logic pol_we = 1'b0;
    logic [2:0] pol_wd = '0;
    logic gie = 1'b0;
    logic ack = 1'b0;
    logic irq;
    logic [4:0] vec;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_vectored uut (
        .clk(clk), .rst(rst),
        .supply_por_i(drv[0]), .supply_lvd_i(lvd),
        .src_i(drv[NS-1:1]),
        .mask_we_i(mask_we), .mask_wdata_i(mask_wd),
        .pol_we_i(pol_we), .pol_wdata_i(pol_wd),
        .gie_i(gie), .ack_i(ack),
        .irq_o(irq), .vec_o(vec)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_mask(input logic [NS-1:0] m);
        mask_wd = m; mask_we = 1'b1; tick(); mask_we = 1'b0;
    endtask

    task automatic set_pol(input logic [2:0] p);
        pol_wd = p; pol_we = 1'b1; tick(); pol_we = 1'b0;
    endtask

    // one-cycle pulse; pins 10..12 go high then low (rising polarity expected)
    task automatic pulse(input logic [NS-1:0] bits);
        drv = bits; tick(); drv = '0; tick();
    endtask

    task automatic drain(output logic [NS-1:0] seen, output bit ordered);
        int last;
        last = -1; seen = '0; ordered = 1'b1;
        for (int n = 0; n < 40; n++) begin
            if (!irq) break;
            if (int'(vec) <= last) ordered = 1'b0;
            last = int'(vec);
            seen[vec] = 1'b1;
            ack = 1'b1; tick(); ack = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [NS-1:0] seen;
        bit ord;
        @(negedge clk); tick(); tick();
        rst = 1'b0;
        tick();

        // R1 / R10 reset state
        chk(irq, 0, "R1 irq after reset");
        chk(vec, 0, "R10 vec after reset");

        // R1: all masked after reset, events stay hidden
        gie = 1'b1;
        pulse('1);
        lvd = 1'b0;
        chk(irq, 0, "R1 all masked after reset");

        // R7 retention + R6 ordering: unmask all, drain everything
        set_mask('1);
        chk(vec, 0, "R6 first vector is 0");
        drain(seen, ord);
        chk(seen, 17'h1ffff, "R7 all retained pending");
        chk(ord, 1, "R6 ascending drain order");

        // R2/R3/R4 single-source sweep
        for (int i = 0; i < NS; i++) begin
            pulse(NS'(1) << i);
            chk(irq, 1, $sformatf("R2 irq for source %0d", i));
            chk(vec, i, $sformatf("R2 vec for source %0d", i));
            drain(seen, ord);
            chk(seen, NS'(1) << i, $sformatf("R2 single event source %0d", i));
        end

        // R3 shared supply line
        lvd = 1'b1; tick(); lvd = 1'b0; tick();
        drain(seen, ord);
        chk(seen, 17'h1, "R3 low-voltage maps to vector 0");
        drv[0] = 1'b1; lvd = 1'b1; tick(); drv[0] = 1'b0; lvd = 1'b0; tick();
        drain(seen, ord);
        chk(seen, 17'h1, "R3 both supply events one vector");
        chk(irq, 0, "R3 no second supply event");

        // R4 / R5 pin polarity sweep
        for (int k = 0; k < 3; k++) begin
            for (int p = 0; p < 2; p++) begin
                set_pol(p[0] ? 3'b111 : 3'b000);
                drv[10+k] = 1'b1; tick();
                drain(seen, ord);
                chk(seen, p[0] ? (NS'(1) << (10+k)) : '0, $sformatf("R4 pin %0d rise pol %0d", k, p));
                repeat (3) tick();
                drain(seen, ord);
                chk(seen, 0, $sformatf("R5 pin %0d held high pol %0d", k, p));
                drv[10+k] = 1'b0; tick();
                drain(seen, ord);
                chk(seen, p[0] ? '0 : (NS'(1) << (10+k)), $sformatf("R4 pin %0d fall pol %0d", k, p));
                repeat (3) tick();
                drain(seen, ord);
                chk(seen, 0, $sformatf("R5 pin %0d held low pol %0d", k, p));
            end
        end
        set_pol(3'b111);

        // R6 pair sweep
        for (int i = 0; i < NS; i++) begin
            for (int j = i + 1; j < NS; j++) begin
                drv = (NS'(1) << i) | (NS'(1) << j); tick(); drv = '0;
                chk(vec, i, $sformatf("R6 pair %0d,%0d", i, j));
                tick();
                drain(seen, ord);
                chk(seen, (NS'(1) << i) | (NS'(1) << j), $sformatf("R6 pair drain %0d,%0d", i, j));
            end
        end

        // R8 global enable
        gie = 1'b0;
        pulse(NS'(1) << 5);
        chk(irq, 0, "R8 gie low blocks irq");
        chk(vec, 0, "R10 vec idle with gie low");
        gie = 1'b1; #1;
        chk(irq, 1, "R8 gie raise presents request");
        chk(vec, 5, "R8 stored vector 5");
        drain(seen, ord);

        // R7 masked pending kept, does not block higher index
        set_mask(~(NS'(1) << 3) & ~(NS'(1) << 7));
        pulse((NS'(1) << 3) | (NS'(1) << 8));
        chk(vec, 8, "R7 masked 3 does not block 8");
        drain(seen, ord);
        chk(seen, NS'(1) << 8, "R7 only enabled drained");
        pulse(NS'(1) << 7);
        chk(irq, 0, "R7 masked 7 hidden");
        set_mask('1);
        chk(vec, 3, "R7 unmask presents 3");
        drain(seen, ord);
        chk(seen, (NS'(1) << 3) | (NS'(1) << 7), "R7 retained 3 and 7");

        // R10 vec idle while pending but masked
        set_mask('0);
        pulse(NS'(1) << 9);
        chk(vec, 0, "R10 vec zero when masked");
        set_mask('1);
        drain(seen, ord);
        chk(seen, NS'(1) << 9, "R10 pending 9 retained");

        // R9 ack collision with new event
        pulse(NS'(1) << 4);
        drv[4] = 1'b1; ack = 1'b1; tick(); drv = '0; ack = 1'b0;
        chk(irq, 1, "R9 new event survives ack");
        chk(vec, 4, "R9 vector 4 still set");
        drain(seen, ord);
        chk(seen, NS'(1) << 4, "R9 single remaining event");

        // R9 ack clears only the presented flag
        pulse((NS'(1) << 2) | (NS'(1) << 6));
        ack = 1'b1; tick(); ack = 1'b0;
        chk(vec, 6, "R9 ack cleared only 2");
        drain(seen, ord);
        chk(seen, NS'(1) << 6, "R9 remaining 6");
        chk(irq, 0, "R9 idle after drain");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule